// File: doc/BRIEF.md
# UART Control and Status Register Unit

This block sits between a Wishbone slave port and a pair of serial engines. Software writes characters into a transmit queue and reads received characters from a receive queue. It also sets the line configuration and the baud divisor, and it selects which FIFO level conditions raise the interrupt line. The block starts the external transmit engine whenever that engine is idle, transmission is enabled and a character is waiting. It accepts each character the external receive engine reports as complete and stores it.

Each queue has a programmable watermark. The transmit pending bit shows that the transmit queue has drained below its mark. The receive pending bit shows that the receive queue has filled past its mark. A build parameter replaces both queues with a single holding register. In that build the watermark fields still read back but have no effect, and the thresholds are fixed.

Top module: `uart_ctrl_regs`

## Requirements
- R1: After reset, txctrl, rxctrl, ie and ip read 0, div reads DIV_RESET (default 0x01B2), txdata reads 0, rxdata reads 0x8000_0000, and tx_en_o, rx_en_o, tx_start_o and irq_o are 0.
- R2: An access to word offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 or 0x18 raises wb_ack_o for exactly one cycle, in the cycle after the request. Any other offset, a misaligned offset or an address at or above 0x20 raises wb_err_o instead. wb_rty_o is never asserted.
- R3: A write to txdata (offset 0x00) with wb_sel_i[0] set enqueues wb_dat_i[7:0]. A write while the transmit queue is full is dropped. Reading txdata returns bit 31 = full and 0 in all other bits.
- R4: While txctrl bit 0 is 1, the engine is idle and the queue is non-empty, tx_start_o pulses for one cycle with the oldest byte on tx_data_o. No further start occurs until tx_done_i has pulsed. No start occurs while txctrl bit 0 is 0.
- R5: A pulse on rx_done_i enqueues rx_data_i, or drops it if the receive queue is full. Reading rxdata (offset 0x04) returns the oldest byte in bits 7:0 with bit 31 = 0 and removes it. On an empty queue the read returns 0x8000_0000.
- R6: txctrl (0x08) holds the enable in bit 0 (drives tx_en_o), the two-stop-bit select in bit 1 (drives tx_stop2_o) and the watermark count in bits 18:16. rxctrl (0x0C) holds the enable in bit 0 (drives rx_en_o) and the count in bits 18:16. Writes update only the bytes enabled by wb_sel_i.
- R7: div (0x18) bits 15:0 drive div_o and read back. Writes honour wb_sel_i.
- R8: ip (0x14) bit 0 is 1 while the transmit level is below the txctrl count. Bit 1 is 1 while the receive level is above the rxctrl count. Writes to ip have no effect.
- R9: irq_o is 1 exactly when some ip bit is 1 and the matching ie (0x10) bit, 0 or 1, is 1.
- R10: With USE_FIFO = 0, each direction holds one character. The full and empty flags show whether that register is occupied, and extra characters are dropped. The count fields are ignored: ip bit 0 is 1 while the transmit register is empty, and ip bit 1 is 1 while the receive register is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_sel_i | input | 4 | Byte lane select |
| wb_adr_i | input | ADR_W | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| wb_err_o | output | 1 | Error for unmapped access |
| wb_rty_o | output | 1 | Retry, held low |
| tx_en_o | output | 1 | Transmitter enable |
| tx_stop2_o | output | 1 | Two stop bits selected |
| rx_en_o | output | 1 | Receiver enable |
| div_o | output | 16 | Baud divisor |
| tx_start_o | output | 1 | Start pulse to transmit engine |
| tx_data_o | output | 8 | Character to transmit |
| tx_done_i | input | 1 | Transmit engine finished |
| rx_done_i | input | 1 | Receive engine has a character |
| rx_data_i | input | 8 | Received character |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that tx_done_i pulses only after a start and before the next one. They also assume that the master drops the strobe after each acknowledge, so that every request is one access. The bench models the transmit engine to keep to that protocol: it answers each start with a single done pulse a few cycles later. Its bus task ends every transfer in the cycle after the response. Receive pulses always last one cycle and never coincide with a transmit handshake that the checks depend on.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  typedef enum logic [2:0] {
    REG_TXDATA = 3'd0,
    REG_RXDATA = 3'd1,
    REG_TXCTRL = 3'd2,
    REG_RXCTRL = 3'd3,
    REG_IE     = 3'd4,
    REG_IP     = 3'd5,
    REG_DIV    = 3'd6,
    REG_NONE   = 3'd7
  } reg_sel_e;

  localparam int FLAG_BIT = 31;
  localparam int CNT_LSB  = 16;
  localparam int CNT_W    = 3;

  function automatic logic [31:0] lane_merge(logic [31:0] cur, logic [31:0] wr, logic [3:0] sel);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = sel[b] ? wr[8*b +: 8] : cur[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W          = 8,
  parameter int DEPTH_LOG2 = 3,
  parameter bit USE_MEM    = 1'b1,
  parameter int LVL_W      = DEPTH_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int CAP   = USE_MEM ? DEPTH : 1;

  logic push_ok, pop_ok;
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  generate
    if (USE_MEM) begin : g_ring
      logic [W-1:0]          mem [DEPTH];
      logic [DEPTH_LOG2-1:0] wr_ptr, rd_ptr;
      logic [LVL_W-1:0]      cnt;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
          cnt    <= '0;
        end else begin
          if (push_ok) wr_ptr <= wr_ptr + 1'b1;
          if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
          case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
          endcase
        end
      end

      always_ff @(posedge clk_i) begin
        if (push_ok) mem[wr_ptr] <= data_i;
      end

      assign data_o  = mem[rd_ptr];
      assign level_o = cnt;
      assign full_o  = (cnt == LVL_W'(DEPTH));
      assign empty_o = (cnt == '0);
    end else begin : g_single
      logic         valid;
      logic [W-1:0] hold;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid <= 1'b0;
          hold  <= '0;
        end else if (push_ok) begin
          valid <= 1'b1;
          hold  <= data_i;
        end else if (pop_ok) begin
          valid <= 1'b0;
        end
      end

      assign data_o  = hold;
      assign level_o = LVL_W'(valid);
      assign full_o  = valid;
      assign empty_o = ~valid;
    end
  endgenerate

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(CAP)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> $stable(level_o)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> level_o == '0); // R5
endmodule

// File: rtl/uart_tx_launch.sv
module uart_tx_launch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         empty_i,
  input  logic [W-1:0] head_i,
  input  logic         done_i,
  output logic         pop_o,
  output logic         start_o,
  output logic [W-1:0] data_o
);
  logic busy_q, launch;

  assign launch = en_i & ~busy_q & ~empty_i;
  assign pop_o  = launch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_o <= 1'b0;
      data_o  <= '0;
    end else begin
      start_o <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        data_o <= head_i;
      end else if (done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R4
  AST_START_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(en_i) && !$past(empty_i)); // R4
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i |=> !start_o); // R4
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regs_pkg::*;
#(
  parameter int          ADR_W      = 8,
  parameter int          CHAR_W     = 8,
  parameter int          DEPTH_LOG2 = 3,
  parameter bit          USE_FIFO   = 1'b1,
  parameter logic [15:0] DIV_RESET  = 16'h01B2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [3:0]        wb_sel_i,
  input  logic [ADR_W-1:0]  wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  output logic              wb_err_o,
  output logic              wb_rty_o,
  output logic              tx_en_o,
  output logic              tx_stop2_o,
  output logic              rx_en_o,
  output logic [15:0]       div_o,
  output logic              tx_start_o,
  output logic [CHAR_W-1:0] tx_data_o,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  output logic              irq_o
);
  localparam int LVL_W = DEPTH_LOG2 + 1;

  logic             req, hit, wr, rd;
  reg_sel_e         idx;
  logic [31:0]      rdata;
  logic             tx_push, tx_pop, tx_full, tx_empty;
  logic             rx_pop, rx_full, rx_empty;
  logic [CHAR_W-1:0] tx_head, rx_head;
  logic [LVL_W-1:0] tx_level, rx_level, tx_thr, rx_thr;
  logic [CNT_W-1:0] tx_cnt_q, rx_cnt_q;
  logic             tx_stop2_q;
  logic [1:0]       ie_q, ip;
  logic [31:0]      txctrl_img, rxctrl_img, ie_img, div_img;

  // bus decode: one request per strobe, answered in the following cycle
  assign req = wb_cyc_i & wb_stb_i & ~wb_ack_o & ~wb_err_o;
  assign idx = reg_sel_e'(wb_adr_i[4:2]);
  assign hit = (wb_adr_i[ADR_W-1:5] == '0) & (wb_adr_i[1:0] == 2'b00) & (idx != REG_NONE);
  assign wr  = req & hit & wb_we_i;
  assign rd  = req & hit & ~wb_we_i;

  assign tx_push = wr & (idx == REG_TXDATA) & wb_sel_i[0];
  assign rx_pop  = rd & (idx == REG_RXDATA);

  assign txctrl_img = {{(32-CNT_LSB-CNT_W){1'b0}}, tx_cnt_q, {(CNT_LSB-2){1'b0}}, tx_stop2_q, tx_en_o};
  assign rxctrl_img = {{(32-CNT_LSB-CNT_W){1'b0}}, rx_cnt_q, {(CNT_LSB-1){1'b0}}, rx_en_o};
  assign ie_img     = {30'b0, ie_q};
  assign div_img    = {16'b0, div_o};

  always_comb begin
    rdata = '0;
    unique case (idx)
      REG_TXDATA: rdata[FLAG_BIT] = tx_full;
      REG_RXDATA: begin
        rdata[FLAG_BIT] = rx_empty;
        if (!rx_empty) rdata[CHAR_W-1:0] = rx_head;
      end
      REG_TXCTRL: rdata = txctrl_img;
      REG_RXCTRL: rdata = rxctrl_img;
      REG_IE:     rdata = ie_img;
      REG_IP:     rdata[1:0] = ip;
      REG_DIV:    rdata = div_img;
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_ack_o <= 1'b0;
      wb_err_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= req & hit;
      wb_err_o <= req & ~hit;
      if (req) wb_dat_o <= rd ? rdata : '0;
    end
  end

  assign wb_rty_o = 1'b0;

  // control registers, byte-lane writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_o    <= 1'b0;
      tx_stop2_q <= 1'b0;
      tx_cnt_q   <= '0;
      rx_en_o    <= 1'b0;
      rx_cnt_q   <= '0;
      ie_q       <= '0;
      div_o      <= DIV_RESET;
    end else if (wr) begin
      unique case (idx)
        REG_TXCTRL: begin
          logic [31:0] n;
          n          = lane_merge(txctrl_img, wb_dat_i, wb_sel_i);
          tx_en_o    <= n[0];
          tx_stop2_q <= n[1];
          tx_cnt_q   <= n[CNT_LSB +: CNT_W];
        end
        REG_RXCTRL: begin
          logic [31:0] n;
          n        = lane_merge(rxctrl_img, wb_dat_i, wb_sel_i);
          rx_en_o  <= n[0];
          rx_cnt_q <= n[CNT_LSB +: CNT_W];
        end
        REG_IE: begin
          logic [31:0] n;
          n    = lane_merge(ie_img, wb_dat_i, wb_sel_i);
          ie_q <= n[1:0];
        end
        REG_DIV: begin
          logic [31:0] n;
          n     = lane_merge(div_img, wb_dat_i, wb_sel_i);
          div_o <= n[15:0];
        end
        default: ;
      endcase
    end
  end

  assign tx_stop2_o = tx_stop2_q;

  uart_fifo #(.W(CHAR_W), .DEPTH_LOG2(DEPTH_LOG2), .USE_MEM(USE_FIFO), .LVL_W(LVL_W)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .pop_i(tx_pop), .data_i(wb_dat_i[CHAR_W-1:0]),
    .data_o(tx_head), .full_o(tx_full), .empty_o(tx_empty), .level_o(tx_level)
  );

  uart_fifo #(.W(CHAR_W), .DEPTH_LOG2(DEPTH_LOG2), .USE_MEM(USE_FIFO), .LVL_W(LVL_W)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_done_i), .pop_i(rx_pop), .data_i(rx_data_i),
    .data_o(rx_head), .full_o(rx_full), .empty_o(rx_empty), .level_o(rx_level)
  );

  uart_tx_launch #(.W(CHAR_W)) u_tx_launch (
    .clk_i, .rst_ni,
    .en_i(tx_en_o), .empty_i(tx_empty), .head_i(tx_head), .done_i(tx_done_i),
    .pop_o(tx_pop), .start_o(tx_start_o), .data_o(tx_data_o)
  );

  // watermark thresholds; fixed when storage collapses to one register
  generate
    if (USE_FIFO) begin : g_prog_wm
      assign tx_thr = LVL_W'(tx_cnt_q);
      assign rx_thr = LVL_W'(rx_cnt_q);
    end else begin : g_fixed_wm
      assign tx_thr = LVL_W'(1);
      assign rx_thr = '0;
    end
  endgenerate

  assign ip[0] = tx_level < tx_thr;
  assign ip[1] = rx_level > rx_thr;
  assign irq_o = |(ip & ie_q);

  AST_ACK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_ack_o && wb_err_o)); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o); // R2
  AST_ACK_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_ack_o || wb_err_o) |-> $past(wb_cyc_i && wb_stb_i)); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_q == 2'b00 |-> !irq_o); // R9
  AST_TX_FULL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full |-> !tx_empty); // R3
endmodule

// File: tb/uart_ctrl_regs_bench.sv
module uart_ctrl_regs_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        cyc = 0, stb = 0, we = 0;
  logic [3:0]  sel = 0;
  logic [7:0]  adr = 0;
  logic [31:0] dat_w = 0;
  logic        tx_done = 0, rx_done = 0;
  logic [7:0]  rx_data = 0;

  logic [31:0] dat_m, dat_n;
  logic ack_m, err_m, rty_m, ack_n, err_n, rty_n;
  logic txen_m, stop2_m, rxen_m, start_m, irq_m;
  logic txen_n, stop2_n, rxen_n, start_n, irq_n;
  logic [15:0] div_m, div_n;
  logic [7:0] txd_m, txd_n;

  uart_ctrl_regs u_uart_ctrl_regs (
    .clk_i(clk), .rst_ni, .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_sel_i(sel),
    .wb_adr_i(adr), .wb_dat_i(dat_w), .wb_dat_o(dat_m), .wb_ack_o(ack_m), .wb_err_o(err_m),
    .wb_rty_o(rty_m), .tx_en_o(txen_m), .tx_stop2_o(stop2_m), .rx_en_o(rxen_m), .div_o(div_m),
    .tx_start_o(start_m), .tx_data_o(txd_m), .tx_done_i(tx_done), .rx_done_i(rx_done),
    .rx_data_i(rx_data), .irq_o(irq_m));

  uart_ctrl_regs #(.USE_FIFO(1'b0)) u_uart_ctrl_regs_nf (
    .clk_i(clk), .rst_ni, .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_sel_i(sel),
    .wb_adr_i(adr), .wb_dat_i(dat_w), .wb_dat_o(dat_n), .wb_ack_o(ack_n), .wb_err_o(err_n),
    .wb_rty_o(rty_n), .tx_en_o(txen_n), .tx_stop2_o(stop2_n), .rx_en_o(rxen_n), .div_o(div_n),
    .tx_start_o(start_n), .tx_data_o(txd_n), .tx_done_i(tx_done), .rx_done_i(rx_done),
    .rx_data_i(rx_data), .irq_o(irq_n));

  int checks = 0, errors = 0;
  int starts_m = 0, starts_n = 0;
  logic [7:0] last_n = 0;
  bit sb_on = 0, rty_seen = 0, done_flag = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [31:0] r_dat, r_dat_n;
  logic r_ack, r_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; dat_w = d; sel = s;
    @(posedge clk);
    @(negedge clk);
    r_ack = ack_m; r_err = err_m; r_dat = dat_m; r_dat_n = dat_n;
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 4'hF);
  endtask

  task automatic rd32(input logic [7:0] a);
    bus(1'b0, a, 32'h0, 4'hF);
  endtask

  // driver: queues the expected launch order
  task automatic tx_put(input logic [7:0] b);
    wr32(8'h00, {24'h0, b});
    tx_q.push_back(b);
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    rx_done = 1; rx_data = b;
    @(negedge clk);
    rx_done = 0;
    if (sb_on && rx_q.size() < 8) rx_q.push_back(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  // transmit engine model: one done pulse per start
  initial forever begin
    @(negedge clk);
    if (rst_ni && start_m) begin
      repeat (3) @(negedge clk);
      tx_done = 1;
      @(negedge clk);
      tx_done = 0;
    end
  end

  // monitor: compares launched bytes against the scoreboard
  initial forever begin
    @(negedge clk);
    if (rty_m || rty_n) rty_seen = 1;
    if (rst_ni && start_n) begin starts_n++; last_n = txd_n; end
    if (rst_ni && start_m) begin
      starts_m++;
      if (sb_on) begin
        if (tx_q.size() == 0) chk("R4 unexpected start", {24'h0, txd_m}, 32'hFFFF_FFFF);
        else chk("R4 launch order", {24'h0, txd_m}, {24'h0, tx_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    sb_on = 1;
    // R1
    chk("R1 tx_en", {31'h0, txen_m}, 0);
    chk("R1 rx_en", {31'h0, rxen_m}, 0);
    chk("R1 irq", {31'h0, irq_m}, 0);
    rd32(8'h08); chk("R1 txctrl", r_dat, 0);
    rd32(8'h0C); chk("R1 rxctrl", r_dat, 0);
    rd32(8'h10); chk("R1 ie", r_dat, 0);
    rd32(8'h14); chk("R1 ip", r_dat, 0);
    rd32(8'h18); chk("R1 div", r_dat, 32'h01B2);
    rd32(8'h00); chk("R1 txdata", r_dat, 0);
    rd32(8'h04); chk("R1 rxdata", r_dat, 32'h8000_0000);
    // R2
    rd32(8'h18); chk("R2 ack mapped", {30'h0, r_ack, r_err}, 32'h2);
    rd32(8'h1C); chk("R2 err 0x1C", {30'h0, r_ack, r_err}, 32'h1);
    rd32(8'h20); chk("R2 err 0x20", {30'h0, r_ack, r_err}, 32'h1);
    rd32(8'h0A); chk("R2 err misaligned", {30'h0, r_ack, r_err}, 32'h1);
    chk("R2 ack one cycle", {31'h0, ack_m}, 0);
    // R7
    wr32(8'h18, 32'h0000_1234);
    chk("R7 div_o", {16'h0, div_m}, 32'h1234);
    bus(1'b1, 8'h18, 32'h0000_5600, 4'b0010);
    rd32(8'h18); chk("R7 div lane write", r_dat, 32'h5634);
    // R6
    bus(1'b1, 8'h08, 32'h0007_0003, 4'b0001);
    chk("R6 tx_en/stop2", {30'h0, stop2_m, txen_m}, 32'h3);
    rd32(8'h08); chk("R6 txctrl lane", r_dat, 32'h3);
    wr32(8'h08, 32'h0003_0000);
    rd32(8'h08); chk("R6 txctrl count", r_dat, 32'h0003_0000);
    chk("R6 tx_en off", {31'h0, txen_m}, 0);
    wr32(8'h0C, 32'h0001_0001);
    chk("R6 rx_en", {31'h0, rxen_m}, 1);
    rd32(8'h0C); chk("R6 rxctrl", r_dat, 32'h0001_0001);
    // R8 / R9 transmit watermark
    rd32(8'h14); chk("R8 txwm empty", r_dat, 32'h1);
    chk("R9 masked", {31'h0, irq_m}, 0);
    wr32(8'h10, 32'h1);
    chk("R9 irq txwm", {31'h0, irq_m}, 1);
    tx_put(8'hA1); tx_put(8'hA2);
    rd32(8'h14); chk("R8 level 2 < 3", r_dat, 32'h1);
    tx_put(8'hA3);
    rd32(8'h14); chk("R8 level 3 not < 3", r_dat, 32'h0);
    chk("R9 irq cleared", {31'h0, irq_m}, 0);
    wr32(8'h14, 32'h3);
    rd32(8'h14); chk("R8 ip write ignored", r_dat, 32'h0);
    // R3 full and drop
    for (int i = 4; i <= 8; i++) tx_put(8'hA0 + 8'(i));
    rd32(8'h00); chk("R3 full flag", r_dat, 32'h8000_0000);
    wr32(8'h00, 32'hEE);
    chk("R4 no start while disabled", starts_m, 0);
    // R4 drain
    wr32(8'h08, 32'h0003_0001);
    repeat (100) @(negedge clk);
    chk("R4 start count", starts_m, 8);
    chk("R3 dropped byte absent", tx_q.size(), 0);
    rd32(8'h00); chk("R3 not full", r_dat, 0);
    // R5 / R8 receive
    wr32(8'h10, 32'h2);
    rx_put(8'h11);
    rd32(8'h14); chk("R8 rx level 1 not > 1", r_dat[1], 0);
    rx_put(8'h22);
    rd32(8'h14); chk("R8 rxwm", r_dat[1], 1);
    chk("R9 irq rxwm", {31'h0, irq_m}, 1);
    for (int i = 3; i <= 9; i++) rx_put(8'(i * 8'h11));
    for (int i = 0; i < 8; i++) begin
      rd32(8'h04);
      chk("R5 rx order", r_dat, {24'h0, rx_q.pop_front()});
    end
    rd32(8'h04); chk("R5 empty read", r_dat, 32'h8000_0000);
    rd32(8'h14); chk("R8 rxwm clear", r_dat[1], 0);
    // R10 single-register build
    sb_on = 0;
    do_reset();
    starts_n = 0;
    wr32(8'h00, 32'h5A);
    rd32(8'h00); chk("R10 tx occupied", r_dat_n, 32'h8000_0000);
    wr32(8'h08, 32'h0007_0000);
    rd32(8'h14); chk("R10 txwm fixed", r_dat_n[0], 0);
    wr32(8'h00, 32'h6B);
    wr32(8'h08, 32'h0007_0001);
    repeat (20) @(negedge clk);
    chk("R10 one start", starts_n, 1);
    chk("R10 kept first byte", {24'h0, last_n}, 32'h5A);
    rd32(8'h14); chk("R10 txwm empty", r_dat_n[0], 1);
    wr32(8'h0C, 32'h0007_0000);
    rx_put(8'h3C);
    rd32(8'h14); chk("R10 rxwm occupied", r_dat_n[1], 1);
    rx_put(8'h4D);
    rd32(8'h04); chk("R10 rx first kept", r_dat_n, 32'h3C);
    rd32(8'h04); chk("R10 rx empty", r_dat_n, 32'h8000_0000);
    chk("R2 retry never", {31'h0, rty_seen}, 0);
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule